// File: doc/BRIEF.md
# System Clock Ratio Detector and Frame Sync Monitor

This block runs entirely on the audio system clock. It measures how many system-clock cycles lie between successive rising edges of the frame (left/right) clock. From that measurement it decides which of six legal oversampling ratios is in use: 128, 192, 256, 384, 512 or 768 system-clock cycles per sample. Once it has locked onto a ratio, it keeps comparing each new measured period with the nominal one. A small wander is tolerated. A larger slip, or a frame clock that stops, is declared a loss of synchronization.

The outputs drive the rest of a converter's digital section. They are a ratio code, a flag that allows the analog-to-digital path to run, a synchronized flag, and separate mute requests for the digital-to-analog and analog-to-digital paths. Each mute request is held for a programmable number of frames after lock is regained, so that both paths only resume once the clocks have settled. The analog-to-digital path is kept disabled and muted for the two lowest ratios. The block needs no fixed phase between the system clock and the frame clock, only a constant relationship between them. The frame clock is assumed to have a fixed number of bit-clock periods per frame (64 by default), and slip is judged in those bit-clock units.

Top module: `clk_ratio_monitor`

## Requirements
- R1: While locked, `ratio_code` reports the ratio as 1=128, 2=192, 3=256, 4=384, 5=512, 6=768 cycles per frame; while not locked it reads 0.
- R2: Lock is gained at a frame-clock rising edge whose measured period equals one of the six legal ratios and equals the period measured at the edge before; `synced` then goes high.
- R3: At ratio codes 1 and 2, `adc_enable` is low and `adc_mute` stays high for as long as the lock holds; at codes 3 to 6, `adc_enable` is high while locked.
- R4: While locked, a measured period that differs from the nominal one by at most 6 bit-clock periods (6 × ratio / 64 system-clock cycles) keeps the lock and the ratio code, and does not raise either mute.
- R5: While locked, a measured period differing from the nominal by more than 6 bit-clock periods ends the lock. So does a count since the last rising edge that exceeds nominal plus that limit (a stalled frame clock). Both mutes rise, `synced` falls and `ratio_code` returns to 0 in the next cycle.
- R6: After lock is gained, `dac_mute` and `adc_mute` stay high until 32 further frame-clock rising edges have been seen while locked, and then fall.
- R7: Periods that match no legal ratio (for example 300 or 257 cycles) never produce a lock.
- R8: During and right after reset, `synced` and `adc_enable` are low, `ratio_code` is 0 and both mutes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame (left/right) clock, sampled on clk |
| ratio_code | output | 3 | Detected ratio code, 0 when not locked |
| adc_enable | output | 1 | Analog-to-digital path may run |
| synced | output | 1 | Lock held on a legal ratio |
| dac_mute | output | 1 | Force digital-to-analog output to mid-level |
| adc_mute | output | 1 | Force analog-to-digital output to zero |

## Verification
The hardest situation to reach from the ports is a period that sits exactly on the slip boundary. Such a period must keep the lock, while one cycle more must break it. The boundary scales with the detected ratio, and the comparison only takes place at the rising edge that closes the odd frame. The bench reaches it by first locking and completing recovery at a known ratio. It then shapes single frames of exactly nominal ±24 cycles and nominal −26 cycles at ratio 256, and nominal +12 cycles at ratio 128. A separate frame longer than the limit makes the stall path fire before the closing edge arrives.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    localparam int CNT_W      = 12;
    localparam int FRAME_BITS = 64;
    localparam int SLIP_BITS  = 6;
    localparam int RECOVER_FRAMES = 32;
    localparam int NUM_RATIOS = 6;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        RC_NONE = 3'd0,
        RC_128  = 3'd1,
        RC_192  = 3'd2,
        RC_256  = 3'd3,
        RC_384  = 3'd4,
        RC_512  = 3'd5,
        RC_768  = 3'd6
    } ratio_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
        ratio_e      ratio;
    } lock_t;

    function automatic cnt_t nominal(input ratio_e c);
        case (c)
            RC_128:  return cnt_t'(128);
            RC_192:  return cnt_t'(192);
            RC_256:  return cnt_t'(256);
            RC_384:  return cnt_t'(384);
            RC_512:  return cnt_t'(512);
            RC_768:  return cnt_t'(768);
            default: return cnt_t'(0);
        endcase
    endfunction

    function automatic cnt_t slip_limit(input ratio_e c);
        return cnt_t'((int'(nominal(c)) / FRAME_BITS) * SLIP_BITS);
    endfunction

    function automatic ratio_e classify(input cnt_t period);
        ratio_e res;
        res = RC_NONE;
        for (int i = 1; i <= NUM_RATIOS; i++) begin
            if (period == nominal(ratio_e'(3'(i))))
                res = ratio_e'(3'(i));
        end
        return res;
    endfunction

    function automatic logic adc_allowed(input ratio_e c);
        return (c != RC_NONE) && (c != RC_128) && (c != RC_192);
    endfunction

endpackage

// File: rtl/clkmon_edge.sv
module clkmon_edge (
    input  logic clk,
    input  logic rst,
    input  logic frame_in,
    output logic rise
);
    logic s1, s2, sd;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            sd <= 1'b0;
        end else begin
            s1 <= frame_in;
            s2 <= s1;
            sd <= s2;
        end
    end

    assign rise = s2 & ~sd;
endmodule

// File: rtl/clkmon_period.sv
module clkmon_period
    import clkmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output cnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (rise)
            cnt <= cnt_t'(1);
        else if (cnt != '1)
            cnt <= cnt + cnt_t'(1);
    end
endmodule

// File: rtl/clkmon_lock.sv
module clkmon_lock
    import clkmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  cnt_t  cnt,
    output lock_t lock
);
    cnt_t   prev_period;
    ratio_e cand;
    cnt_t   nom, lim, dev;
    logic   slip, stall;

    always_comb begin
        cand  = classify(cnt);
        nom   = nominal(lock.ratio);
        lim   = slip_limit(lock.ratio);
        dev   = (cnt >= nom) ? (cnt - nom) : (nom - cnt);
        slip  = dev > lim;
        stall = cnt > (nom + lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock.state  <= ST_HUNT;
            lock.ratio  <= RC_NONE;
            prev_period <= '0;
        end else begin
            if (rise)
                prev_period <= cnt;
            case (lock.state)
                ST_HUNT: begin
                    if (rise && (cand != RC_NONE) && (cnt == prev_period)) begin
                        lock.state <= ST_LOCK;
                        lock.ratio <= cand;
                    end
                end
                default: begin
                    if ((rise && slip) || (!rise && stall)) begin
                        lock.state <= ST_HUNT;
                        lock.ratio <= RC_NONE;
                    end
                end
            endcase
        end
    end

    p_lock_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(lock.state == ST_LOCK) |-> $past(rise));

    p_ratio_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ((lock.state == ST_LOCK) && $past(lock.state == ST_LOCK)) |-> $stable(lock.ratio));

    p_none_hunting_r1: assert property (@(posedge clk) disable iff (rst)
        (lock.state == ST_HUNT) |-> (lock.ratio == RC_NONE));

    p_slip_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
        ((lock.state == ST_LOCK) && rise && slip) |=> (lock.state == ST_HUNT));
endmodule

// File: rtl/clkmon_recover.sv
module clkmon_recover
    import clkmon_pkg::*;
#(
    parameter int DAC_HOLD = RECOVER_FRAMES,
    parameter int ADC_HOLD = RECOVER_FRAMES
)(
    input  logic clk,
    input  logic rst,
    input  logic locked,
    input  logic rise,
    output logic dac_ok,
    output logic adc_ok
);
    localparam int REC_MAX = (DAC_HOLD > ADC_HOLD) ? DAC_HOLD : ADC_HOLD;
    localparam int REC_W   = $clog2(REC_MAX + 1);

    logic [REC_W-1:0] rec;

    always_ff @(posedge clk) begin
        if (rst || !locked)
            rec <= '0;
        else if (rise && (rec != REC_W'(REC_MAX)))
            rec <= rec + 1'b1;
    end

    assign dac_ok = locked && (rec >= REC_W'(DAC_HOLD));
    assign adc_ok = locked && (rec >= REC_W'(ADC_HOLD));

    p_rec_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (rec == '0));

    p_rec_step_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> ((rec == $past(rec)) || (rec == $past(rec) + 1'b1)));
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
    import clkmon_pkg::*;
#(
    parameter int DAC_HOLD = RECOVER_FRAMES,
    parameter int ADC_HOLD = RECOVER_FRAMES
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_clk,
    output logic [2:0] ratio_code,
    output logic       adc_enable,
    output logic       synced,
    output logic       dac_mute,
    output logic       adc_mute
);
    logic  rise;
    cnt_t  cnt;
    lock_t lock;
    logic  locked, dac_ok, adc_ok;

    clkmon_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .frame_in (frame_clk),
        .rise     (rise)
    );

    clkmon_period u_period (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .cnt  (cnt)
    );

    clkmon_lock u_lock (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .cnt  (cnt),
        .lock (lock)
    );

    assign locked = (lock.state == ST_LOCK);

    clkmon_recover #(.DAC_HOLD(DAC_HOLD), .ADC_HOLD(ADC_HOLD)) u_recover (
        .clk    (clk),
        .rst    (rst),
        .locked (locked),
        .rise   (rise),
        .dac_ok (dac_ok),
        .adc_ok (adc_ok)
    );

    assign ratio_code = lock.ratio;
    assign synced     = locked;
    assign adc_enable = locked && adc_allowed(lock.ratio);
    assign dac_mute   = !dac_ok;
    assign adc_mute   = !(adc_ok && adc_enable);

    p_adc_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (synced && ((ratio_code == 3'd1) || (ratio_code == 3'd2))) |-> (!adc_enable && adc_mute));

    p_unmute_needs_sync_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_mute) |-> synced);

    p_mute_when_lost_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(synced) |-> (dac_mute && adc_mute && (ratio_code == 3'd0)));
endmodule

// File: tb/test_clk_ratio_monitor.sv
`timescale 1ns/1ps
module test_clk_ratio_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_clk = 1'b0;
    logic [2:0] ratio_code;
    logic       adc_enable, synced, dac_mute, adc_mute;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clk_ratio_monitor i_clk_ratio_monitor (
        .clk        (clk),
        .rst        (rst),
        .frame_clk  (frame_clk),
        .ratio_code (ratio_code),
        .adc_enable (adc_enable),
        .synced     (synced),
        .dac_mute   (dac_mute),
        .adc_mute   (adc_mute)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_clk = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic frames(input int period, input int n);
        for (int f = 0; f < n; f++) begin
            frame_clk = 1'b1;
            for (int c = 0; c < period; c++) begin
                if (c == period / 2) frame_clk = 1'b0;
                @(negedge clk);
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "synced in reset", synced, 0);
        chk("R8", "code in reset", ratio_code, 0);
        chk("R8", "dac_mute in reset", dac_mute, 1);
        chk("R8", "adc_mute in reset", adc_mute, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", "adc_enable after reset", adc_enable, 0);
    endtask

    task automatic test_lock_and_recover();
        do_reset();
        frames(256, 2);
        chk("R2", "no lock after one matching period", synced, 0);
        frames(256, 1);
        chk("R2", "lock on second equal period", synced, 1);
        chk("R1", "code for 256", ratio_code, 3);
        chk("R6", "dac_mute right after lock", dac_mute, 1);
        frames(256, 31);
        chk("R6", "dac_mute after 31 edges", dac_mute, 1);
        chk("R6", "adc_mute after 31 edges", adc_mute, 1);
        frames(256, 1);
        chk("R6", "dac_mute after 32 edges", dac_mute, 0);
        chk("R6", "adc_mute after 32 edges", adc_mute, 0);
        chk("R3", "adc_enable at 256", adc_enable, 1);
    endtask

    task automatic test_all_ratios();
        int ratios[6] = '{128, 192, 256, 384, 512, 768};
        for (int i = 0; i < 6; i++) begin
            do_reset();
            frames(ratios[i], 3);
            chk("R1", $sformatf("code for %0d", ratios[i]), ratio_code, i + 1);
            chk("R3", $sformatf("adc_enable for %0d", ratios[i]), adc_enable, (i >= 2) ? 1 : 0);
        end
    endtask

    task automatic test_low_ratio_adc();
        do_reset();
        frames(128, 40);
        chk("R3", "synced at 128", synced, 1);
        chk("R3", "adc_enable at 128", adc_enable, 0);
        chk("R3", "adc_mute held at 128", adc_mute, 1);
        chk("R3", "dac_mute released at 128", dac_mute, 0);
        frames(128, 1);
        frames(140, 1);
        frames(116, 1);
        frames(128, 2);
        chk("R4", "128 keeps lock at +-12 cycles", synced, 1);
        chk("R4", "dac_mute stays low at 128 boundary", dac_mute, 0);
    endtask

    task automatic test_small_drift();
        do_reset();
        frames(256, 35);
        frames(272, 1);
        frames(240, 1);
        frames(280, 1);
        frames(232, 1);
        frames(256, 2);
        chk("R4", "lock held under tolerated drift", synced, 1);
        chk("R4", "code unchanged under drift", ratio_code, 3);
        chk("R4", "dac_mute stays low under drift", dac_mute, 0);
        chk("R4", "adc_mute stays low under drift", adc_mute, 0);
    endtask

    task automatic test_slip_short();
        do_reset();
        frames(256, 35);
        frames(230, 1);
        frames(256, 1);
        chk("R5", "short slip drops lock", synced, 0);
        chk("R5", "code cleared after slip", ratio_code, 0);
        chk("R5", "dac_mute after slip", dac_mute, 1);
        chk("R5", "adc_mute after slip", adc_mute, 1);
    endtask

    task automatic test_slip_long_relock();
        do_reset();
        frames(256, 35);
        frames(284, 1);
        frames(256, 2);
        chk("R5", "long frame drops lock", synced, 0);
        frames(256, 1);
        chk("R2", "relock after two equal periods", synced, 1);
        frames(256, 31);
        chk("R6", "mute held 31 edges after relock", dac_mute, 1);
        frames(256, 1);
        chk("R6", "mute released 32 edges after relock", dac_mute, 0);
    endtask

    task automatic test_stall();
        do_reset();
        frames(512, 36);
        chk("R4", "locked at 512 before stall", synced, 1);
        frame_clk = 1'b0;
        repeat (1000) @(negedge clk);
        chk("R5", "stalled frame clock drops lock", synced, 0);
        chk("R5", "mute on stall", dac_mute, 1);
    endtask

    task automatic test_illegal();
        do_reset();
        frames(300, 10);
        chk("R7", "no lock at 300", synced, 0);
        chk("R7", "code 0 at 300", ratio_code, 0);
        frames(257, 10);
        chk("R7", "no lock at 257", synced, 0);
        chk("R7", "adc_mute at 257", adc_mute, 1);
    endtask

    initial begin
        fork
            begin
                repeat (199000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        test_reset();
        test_lock_and_recover();
        test_all_ratios();
        test_low_ratio_adc();
        test_small_drift();
        test_slip_short();
        test_slip_long_relock();
        test_stall();
        test_illegal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule